// File: doc/BRIEF.md
# DQS Delay Window Search Sequencer

This block calibrates the strobe timing of a DDR memory interface without software help. It walks a two-level grid of settings. The outer level is a write-strobe shift. A second output shift always tracks it at a fixed offset. The inner level is a read-strobe delay-line value that is driven identically onto every byte lane. For each grid point the memory controller is restarted, and the sequencer waits for delay-line lock, for initialisation complete and for a settle time. It then asks an external pattern tester for a pass or fail verdict.

While the grid is walked, the block keeps the longest unbroken run of passing delay values found within one outer step. When two runs have the same length, the one found later is kept. At the end it drives the winning shift and the midpoint of the winning run, and restarts the controller one last time before it reports completion. If a lock or an initialisation wait lasts too long, the block stops in an error state that only reset clears. The settings of the failing trial stay on the outputs.

Top module: `dqs_eye_search`

## Requirements
- R1: The outer sweep steps `wr_shift` upward from SHIFT_FIRST (default 64) through SHIFT_FIRST+SHIFT_COUNT-1 (default 95). `out_shift` always equals `wr_shift` plus SHIFT_OFFSET (default 32).
- R2: Within each outer step the delay steps upward from DLY_FIRST (default 1) through DLY_LAST (default 63), so trials run in shift-major order. Every lane k of `rd_dly` (bits [k*DLY_W +: DLY_W], nine lanes by default) carries the same value.
- R3: A trial drops `ctl_start` and pulses `err_ack` for one cycle with `ack_code` = 0x3C (`ack_code` is 0 otherwise). It raises `ctl_start` in the next cycle, waits for `dll_lock`, then for `init_done`, then for SETTLE_CYC cycles. It then holds `test_req` high until `test_ack`, and finally drops `ctl_start`.
- R4: The verdict is `test_pass` sampled in the cycle where `test_ack` is high while `test_req` is high.
- R5: If `dll_lock` or `init_done` does not arrive within POLL_LIMIT cycles of waiting, `err` rises and stays high until reset. `done` stays low, and `wr_shift`/`rd_dly` keep the failing trial's values.
- R6: The passing-run length clears at the start of every outer step and on every failing trial. A pass with a zero run length makes the current delay the run's start, so a run never spans two outer steps.
- R7: After each pass, a run length that is greater than or equal to the best length so far replaces the best window (length, shift, start, end). Equal-length windows found later therefore win.
- R8: After the sweep the block drives the best shift, that shift plus the offset, and delay floor((start+end)/2). It then restarts the controller once with no `err_ack` pulse, waits for lock, init and settle, and raises `done` with `ctl_start` left high.
- R9: If no trial passes, `done` and `no_window` rise together, with `wr_shift` = SHIFT_FIRST, delay 0 and `ctl_start` low.
- R10: After reset: `done`, `err`, `no_window`, `ctl_start`, `err_ack` and `test_req` are 0, `wr_shift` = SHIFT_FIRST and delay = 0. `go` is accepted only when the block is idle and not in error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start a calibration when idle |
| done | output | 1 | Calibration finished |
| no_window | output | 1 | Finished with no passing trial |
| err | output | 1 | Sticky wait-timeout error |
| wr_shift | output | SHIFT_W | Write-strobe shift setting |
| out_shift | output | SHIFT_W | Derived output shift setting |
| rd_dly | output | LANES*DLY_W | Per-lane read delay settings |
| ctl_start | output | 1 | Controller start strobe |
| err_ack | output | 1 | Error-status acknowledge pulse |
| ack_code | output | ACK_W | Acknowledge code, valid with err_ack |
| dll_lock | input | 1 | Delay line locked |
| init_done | input | 1 | Controller initialisation complete |
| test_req | output | 1 | Request a pattern test |
| test_ack | input | 1 | Test verdict valid |
| test_pass | input | 1 | Test verdict, 1 = pass |

## Verification
The hardest case to reach from the ports is a tie or near-tie between windows. This includes a run that ends on the last delay of one outer step next to a run that starts on the first delay of the next step: a wrongly joined run would beat the correct one. The bench therefore drives pass maps, one bit per shift and delay, that place such windows on purpose. It adds randomly dense maps, an all-pass and an all-fail map, and suppressed lock or init responses to reach the timeout error. The sweep is shrunk by parameter so that many complete calibrations fit in one run.

// File: rtl/dqs_search_pkg.sv
package dqs_search_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PREP,
    ST_RAISE,
    ST_LOCK,
    ST_INIT,
    ST_SETTLE,
    ST_TEST,
    ST_NEXT,
    ST_ERR
  } seq_state_e;

  function automatic int unsigned bits_for(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/dqs_wait_counter.sv
module dqs_wait_counter #(
  parameter int unsigned POLL_LIMIT = 65535,
  parameter int unsigned SETTLE_CYC = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic poll_exp,
  output logic settle_hit
);
  localparam int unsigned MAXV = (POLL_LIMIT > SETTLE_CYC) ? POLL_LIMIT : SETTLE_CYC;
  localparam int unsigned CW   = dqs_search_pkg::bits_for(MAXV);
  localparam logic [CW-1:0] POLL_END   = CW'(POLL_LIMIT - 1);
  localparam logic [CW-1:0] SETTLE_END = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] SAT        = CW'(MAXV);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cnt != SAT) cnt <= cnt + 1'b1;
  end

  assign poll_exp   = (cnt == POLL_END);
  assign settle_hit = (cnt == SETTLE_END);

  // R5: counter never runs past its saturation value
  p_cnt_sat_r5: assert property (@(posedge clk) disable iff (rst) cnt <= SAT);
endmodule

// File: rtl/dqs_run_tracker.sv
module dqs_run_tracker #(
  parameter int unsigned SHIFT_W = 7,
  parameter int unsigned DLY_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_all,
  input  logic               clr_run,
  input  logic               valid,
  input  logic               pass,
  input  logic [SHIFT_W-1:0] cur_shift,
  input  logic [DLY_W-1:0]   cur_dly,
  output logic [DLY_W:0]     best_len,
  output logic [SHIFT_W-1:0] best_shift,
  output logic [DLY_W-1:0]   best_start,
  output logic [DLY_W-1:0]   best_end
);
  logic [DLY_W:0]   run_len;
  logic [DLY_W-1:0] run_start;
  logic [DLY_W:0]   next_len;
  logic [DLY_W-1:0] next_start;

  always_comb begin
    next_len   = run_len + 1'b1;
    next_start = (run_len == '0) ? cur_dly : run_start;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      run_len    <= '0;
      run_start  <= '0;
      best_len   <= '0;
      best_shift <= '0;
      best_start <= '0;
      best_end   <= '0;
    end else if (clr_run) begin
      run_len <= '0;
    end else if (valid) begin
      if (!pass) begin
        run_len <= '0;
      end else begin
        run_len   <= next_len;
        run_start <= next_start;
        if (next_len >= best_len) begin
          best_len   <= next_len;
          best_shift <= cur_shift;
          best_start <= next_start;
          best_end   <= cur_dly;
        end
      end
    end
  end

  // R7: the best length only grows between full clears
  p_best_mono_r7: assert property (@(posedge clk) disable iff (rst)
    !clr_all |=> best_len >= $past(best_len));
  // R6: a live run is never longer than the recorded best
  p_run_bound_r6: assert property (@(posedge clk) disable iff (rst) run_len <= best_len);
endmodule

// File: rtl/dqs_eye_search.sv
module dqs_eye_search #(
  parameter int unsigned SHIFT_W      = 7,
  parameter int unsigned DLY_W        = 6,
  parameter int unsigned LANES        = 9,
  parameter int unsigned SHIFT_FIRST  = 64,
  parameter int unsigned SHIFT_COUNT  = 32,
  parameter int unsigned SHIFT_OFFSET = 32,
  parameter int unsigned DLY_FIRST    = 1,
  parameter int unsigned DLY_LAST     = 63,
  parameter int unsigned CLK_HZ       = 100_000_000,
  parameter int unsigned SETTLE_CYC   = CLK_HZ / 10_000,
  parameter int unsigned POLL_LIMIT   = 65535,
  parameter int unsigned ACK_W        = 6,
  parameter int unsigned ACK_CODE     = 60
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   go,
  output logic                   done,
  output logic                   no_window,
  output logic                   err,
  output logic [SHIFT_W-1:0]     wr_shift,
  output logic [SHIFT_W-1:0]     out_shift,
  output logic [LANES*DLY_W-1:0] rd_dly,
  output logic                   ctl_start,
  output logic                   err_ack,
  output logic [ACK_W-1:0]       ack_code,
  input  logic                   dll_lock,
  input  logic                   init_done,
  output logic                   test_req,
  input  logic                   test_ack,
  input  logic                   test_pass
);
  import dqs_search_pkg::*;

  localparam logic [SHIFT_W-1:0] SH_FIRST = SHIFT_W'(SHIFT_FIRST);
  localparam logic [SHIFT_W-1:0] SH_LAST  = SHIFT_W'(SHIFT_FIRST + SHIFT_COUNT - 1);
  localparam logic [SHIFT_W-1:0] SH_OFF   = SHIFT_W'(SHIFT_OFFSET);
  localparam logic [DLY_W-1:0]   DL_FIRST = DLY_W'(DLY_FIRST);
  localparam logic [DLY_W-1:0]   DL_LAST  = DLY_W'(DLY_LAST);
  localparam logic [ACK_W-1:0]   ACK_VAL  = ACK_W'(ACK_CODE);

  seq_state_e state;
  logic [SHIFT_W-1:0] shift_q, oshift_q;
  logic [DLY_W-1:0]   dly_q;
  logic start_q, ack_q, req_q, done_q, nowin_q, err_q, final_q;

  logic cnt_clr, poll_exp, settle_hit;
  logic trk_clr_all, trk_clr_run, trk_valid;
  logic [DLY_W:0]     best_len;
  logic [SHIFT_W-1:0] best_shift;
  logic [DLY_W-1:0]   best_start, best_end;
  logic [DLY_W:0]     centre_sum;

  always_comb begin
    cnt_clr = !(state == ST_LOCK || state == ST_INIT || state == ST_SETTLE)
              || (state == ST_LOCK && dll_lock)
              || (state == ST_INIT && init_done);
    trk_clr_all = (state == ST_IDLE) && go;
    trk_clr_run = (state == ST_NEXT) && (dly_q == DL_LAST);
    trk_valid   = (state == ST_TEST) && req_q && test_ack;
    centre_sum  = {1'b0, best_start} + {1'b0, best_end};
  end

  dqs_wait_counter #(.POLL_LIMIT(POLL_LIMIT), .SETTLE_CYC(SETTLE_CYC)) i_wait (
    .clk(clk), .rst(rst), .clr(cnt_clr), .poll_exp(poll_exp), .settle_hit(settle_hit));

  dqs_run_tracker #(.SHIFT_W(SHIFT_W), .DLY_W(DLY_W)) i_track (
    .clk(clk), .rst(rst), .clr_all(trk_clr_all), .clr_run(trk_clr_run),
    .valid(trk_valid), .pass(test_pass), .cur_shift(shift_q), .cur_dly(dly_q),
    .best_len(best_len), .best_shift(best_shift), .best_start(best_start),
    .best_end(best_end));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      shift_q  <= SH_FIRST;
      oshift_q <= SH_FIRST + SH_OFF;
      dly_q    <= '0;
      start_q  <= 1'b0;
      ack_q    <= 1'b0;
      req_q    <= 1'b0;
      done_q   <= 1'b0;
      nowin_q  <= 1'b0;
      err_q    <= 1'b0;
      final_q  <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      case (state)
        ST_IDLE: if (go) begin
          shift_q  <= SH_FIRST;
          oshift_q <= SH_FIRST + SH_OFF;
          dly_q    <= DL_FIRST;
          done_q   <= 1'b0;
          nowin_q  <= 1'b0;
          final_q  <= 1'b0;
          start_q  <= 1'b0;
          state    <= ST_PREP;
        end
        ST_PREP: begin
          start_q <= 1'b0;
          ack_q   <= !final_q;
          state   <= ST_RAISE;
        end
        ST_RAISE: begin
          start_q <= 1'b1;
          state   <= ST_LOCK;
        end
        ST_LOCK:
          if (dll_lock) state <= ST_INIT;
          else if (poll_exp) begin err_q <= 1'b1; state <= ST_ERR; end
        ST_INIT:
          if (init_done) state <= ST_SETTLE;
          else if (poll_exp) begin err_q <= 1'b1; state <= ST_ERR; end
        ST_SETTLE: if (settle_hit) begin
          if (final_q) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            req_q <= 1'b1;
            state <= ST_TEST;
          end
        end
        ST_TEST: if (test_ack) begin
          req_q <= 1'b0;
          state <= ST_NEXT;
        end
        ST_NEXT: begin
          start_q <= 1'b0;
          state   <= ST_PREP;
          if (dly_q != DL_LAST) begin
            dly_q <= dly_q + 1'b1;
          end else if (shift_q != SH_LAST) begin
            shift_q  <= shift_q + 1'b1;
            oshift_q <= shift_q + 1'b1 + SH_OFF;
            dly_q    <= DL_FIRST;
          end else if (best_len == '0) begin
            shift_q  <= SH_FIRST;
            oshift_q <= SH_FIRST + SH_OFF;
            dly_q    <= '0;
            nowin_q  <= 1'b1;
            done_q   <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            shift_q  <= best_shift;
            oshift_q <= best_shift + SH_OFF;
            dly_q    <= centre_sum[DLY_W:1];
            final_q  <= 1'b1;
          end
        end
        default: state <= ST_ERR;
      endcase
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign rd_dly[k*DLY_W +: DLY_W] = dly_q;
  end

  assign wr_shift  = shift_q;
  assign out_shift = oshift_q;
  assign ctl_start = start_q;
  assign err_ack   = ack_q;
  assign ack_code  = ack_q ? ACK_VAL : '0;
  assign test_req  = req_q;
  assign done      = done_q;
  assign no_window = nowin_q;
  assign err       = err_q;

  // R1: derived shift tracks the write shift
  p_offset_r1: assert property (@(posedge clk) disable iff (rst) oshift_q == shift_q + SH_OFF);
  // R2: a trial only requests a test inside the sweep ranges
  p_req_range_r2: assert property (@(posedge clk) disable iff (rst)
    req_q |-> (shift_q >= SH_FIRST && shift_q <= SH_LAST && dly_q >= DL_FIRST && dly_q <= DL_LAST));
  // R3: start rises only right after the acknowledge pulse during the sweep
  p_ack_before_start_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(start_q) && !final_q) |-> $past(ack_q));
  // R3: a test request only occurs with the controller started
  p_req_started_r3: assert property (@(posedge clk) disable iff (rst) req_q |-> start_q);
  // R5: the error flag is sticky and excludes done
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst) err_q |=> (err_q && !done_q));
  // R9: no-window always comes with done and a stopped controller
  p_nowin_done_r9: assert property (@(posedge clk) disable iff (rst) nowin_q |-> (done_q && !start_q));
endmodule

// File: tb/test_dqs_eye_search.sv
module test_dqs_eye_search;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int DF = 1;
  localparam int DL = 15;
  localparam int LN = 9;
  localparam int DW = 6;
  localparam int SW = 7;

  logic clk = 1'b0, rst = 1'b1, go = 1'b0;
  logic done, no_window, err, ctl_start, err_ack, test_req;
  logic [SW-1:0] wr_shift, out_shift;
  logic [LN*DW-1:0] rd_dly;
  logic [5:0] ack_code;
  logic dll_lock = 1'b0, init_done = 1'b0, test_ack = 1'b0, test_pass = 1'b0;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  bit kill_lock = 0, kill_init = 0;
  logic [15:0] pmap [NS];
  int lag = 1, lk_cnt = 0, tw = 0, tlag = 0;
  int exp_s = 64, exp_d = DF, trials = 0, acks = 0, seq_bad = 0, code_bad = 0;
  bit req_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dqs_eye_search #(.SHIFT_COUNT(NS), .DLY_LAST(DL), .SETTLE_CYC(3), .POLL_LIMIT(40)) i_dqs_eye_search (
    .clk(clk), .rst(rst), .go(go), .done(done), .no_window(no_window), .err(err),
    .wr_shift(wr_shift), .out_shift(out_shift), .rd_dly(rd_dly), .ctl_start(ctl_start),
    .err_ack(err_ack), .ack_code(ack_code), .dll_lock(dll_lock), .init_done(init_done),
    .test_req(test_req), .test_ack(test_ack), .test_pass(test_pass));

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic bit lanes_equal(input int v);
    for (int k = 0; k < LN; k++) if (rd_dly[k*DW +: DW] != DW'(v)) return 0;
    return 1;
  endfunction

  // controller, delay line and tester models, driven away from the active edge
  always @(negedge clk) begin
    if (rst || !ctl_start) begin
      lk_cnt <= 0; dll_lock <= 0; init_done <= 0; lag <= $urandom % 4;
    end else begin
      lk_cnt <= lk_cnt + 1;
      if (!kill_lock && lk_cnt >= lag) dll_lock <= 1;
      if (!kill_init && dll_lock) init_done <= 1;
    end
    if (test_ack) test_ack <= 0;
    else if (test_req) begin
      if (tw >= tlag) begin
        test_ack <= 1;
        test_pass <= pmap[wr_shift - 64][rd_dly[DW-1:0]];
        tw <= 0; tlag <= $urandom % 3;
      end else tw <= tw + 1;
    end
    if (err_ack) begin
      acks <= acks + 1;
      if (ack_code != 6'h3C) code_bad <= code_bad + 1;
    end else if (ack_code != 0) code_bad <= code_bad + 1;
    if (test_req && !req_prev) begin
      if (wr_shift != SW'(exp_s) || !lanes_equal(exp_d) || out_shift != SW'(exp_s + 32))
        seq_bad <= seq_bad + 1;
      trials <= trials + 1;
      if (exp_d == DL) begin exp_d <= DF; exp_s <= exp_s + 1; end
      else exp_d <= exp_d + 1;
    end
    req_prev <= test_req;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic expected(output int es, output int ed, output bit enw);
    int best = 0, bs = 0, bst = 0, ben = 0, run, rs;
    for (int s = 0; s < NS; s++) begin
      run = 0; rs = 0;
      for (int d = DF; d <= DL; d++) begin
        if (pmap[s][d]) begin
          if (run == 0) rs = d;
          run++;
          if (run >= best) begin best = run; bs = s; bst = rs; ben = d; end
        end else run = 0;
      end
    end
    enw = (best == 0);
    es = enw ? 64 : 64 + bs;
    ed = enw ? 0 : (bst + ben) / 2;
  endtask

  task automatic start_run(input bit poke_go);
    int n = 0;
    exp_s = 64; exp_d = DF; trials = 0; acks = 0; seq_bad = 0; code_bad = 0;
    @(negedge clk); go = 1; @(negedge clk); go = 0;
    while (!done && !err && n < 5000) begin
      @(negedge clk); n++;
      if (poke_go && n == 200) go = 1;
      else go = 0;
    end
    go = 0;
    chk(n < 5000, "run completes", n, 5000);
  endtask

  task automatic sweep(input string name, input bit poke_go);
    int es, ed; bit enw;
    expected(es, ed, enw);
    start_run(poke_go);
    @(negedge clk);
    chk(seq_bad == 0, {name, " R1 R2 trial order and settings"}, seq_bad, 0);
    chk(trials == NS * (DL - DF + 1), {name, " R2 trial count"}, trials, NS * (DL - DF + 1));
    chk(acks == trials && code_bad == 0, {name, " R3 ack pulses with code 0x3C, none in final R8"}, acks, trials);
    chk(done && !err && no_window == enw, {name, " R9 done/no_window"}, no_window, enw);
    chk(wr_shift == SW'(es) && out_shift == SW'(es + 32), {name, " R7 R8 final shift"}, wr_shift, es);
    chk(lanes_equal(ed), {name, " R4 R6 R8 final centre delay"}, rd_dly[DW-1:0], ed);
    chk(ctl_start == !enw, {name, " R8 R9 start after finish"}, ctl_start, !enw);
  endtask

  initial begin
    void'($urandom(2024));
    for (int s = 0; s < NS; s++) pmap[s] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(!done && !err && !no_window && !ctl_start && !err_ack && !test_req, "R10 reset flags", done, 0);
    chk(wr_shift == 64 && out_shift == 96 && lanes_equal(0), "R10 reset settings", wr_shift, 64);

    // R7 tie across outer steps: later one wins
    pmap[0] = 16'h001E; pmap[2] = 16'h03C0;
    sweep("tie-rows", 0);
    // R7 tie inside one step; R10 go ignored while busy
    for (int s = 0; s < NS; s++) pmap[s] = 0;
    pmap[1] = 16'h1C1C;
    sweep("tie-in-row", 1);
    // R6 run must not join across outer-step boundary
    for (int s = 0; s < NS; s++) pmap[s] = 0;
    pmap[0] = 16'hF000; pmap[1] = 16'h000E;
    sweep("boundary", 0);
    // R8 odd sum floors
    for (int s = 0; s < NS; s++) pmap[s] = 0;
    pmap[3] = 16'h000C;
    sweep("floor", 0);
    // R7 all pass: last step wins
    for (int s = 0; s < NS; s++) pmap[s] = 16'hFFFE;
    sweep("all-pass", 0);
    // R9 all fail
    for (int s = 0; s < NS; s++) pmap[s] = 0;
    sweep("all-fail", 0);
    // random dense maps
    for (int r = 0; r < 5; r++) begin
      for (int s = 0; s < NS; s++) pmap[s] = 16'($urandom | $urandom);
      sweep("random", 0);
    end

    // R5 lock timeout
    kill_lock = 1;
    start_run(0);
    chk(err && !done, "R5 lock timeout err", err, 1);
    chk(wr_shift == 64 && lanes_equal(DF), "R5 settings held", wr_shift, 64);
    repeat (60) @(negedge clk);
    go = 1; @(negedge clk); go = 0;
    repeat (20) @(negedge clk);
    chk(err && !done && !test_req, "R5 R10 err sticky, go ignored", err, 1);
    rst = 1; kill_lock = 0; @(negedge clk); rst = 0; @(negedge clk);
    chk(!err && !done && wr_shift == 64 && lanes_equal(0), "R10 reset clears err", err, 0);

    // R5 init timeout
    kill_init = 1;
    start_run(0);
    chk(err && !done, "R5 init timeout err", err, 1);
    rst = 1; kill_init = 0; @(negedge clk); rst = 0; @(negedge clk);

    for (int s = 0; s < NS; s++) pmap[s] = 16'($urandom);
    sweep("after-err", 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule